// File: doc/BRIEF.md
# Multi-context folding logic element

This block is a single reconfigurable logic element that evaluates a different Boolean function on successive clock cycles. It holds sixteen configuration contexts. Each context holds a 4-input truth table, an output-select bit and a feedback-select bit. A context pointer steps through the contexts under a folding-level schedule, so a chain of look-up stages can be computed one stage per cycle in the same element. A flip-flop captures the look-up result on every clock edge. When a context enables feedback, that registered value replaces the top LUT input, so an intermediate result carries into the next stage.

Contexts are written through a simple write port at any time. The folding level p sets how many evaluation cycles the element spends in each context before the pointer advances. The level is sampled only while reset is held. Sequencing is a three-state machine. `ST_HOLD` is entered on reset and is the first evaluation cycle. `ST_EVAL` covers evaluation cycles that are not the last of a context. `ST_LAST` marks the final evaluation cycle before the pointer advances. The transitions are as follows:
- From `ST_HOLD` or `ST_EVAL`, the machine goes to `ST_LAST` when the next count equals p−1, and to `ST_EVAL` otherwise.
- From `ST_LAST`, it goes to `ST_EVAL`, or stays in `ST_LAST` when p = 1.
- Reset forces `ST_HOLD` from any state.

Top module: `mctx_fold_cell`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `active_ctx` is 0 and `reg_out` is 0.
- R2: `lut_out` equals bit A of the active context's 16-bit truth table, where A = {in3, din[2], din[1], din[0]} and in3 is `din[3]` when feedback is off.
- R3: At every clock edge with `rst` low, `reg_out` takes the value `lut_out` had just before that edge.
- R4: `sel_out` equals `reg_out` when the active context's output-select bit is 1, and equals `lut_out` when that bit is 0.
- R5: When the active context's feedback bit is 1, address bit 3 is taken from `reg_out` and `din[3]` has no effect on `lut_out`.
- R6: At folding level p, `active_ctx` holds each value for exactly p consecutive evaluation cycles and then increments by one.
- R7: `active_ctx` wraps from 15 to 0.
- R8: `fold_lvl` is sampled only while `rst` is high. Changes to it while running do not alter the schedule.
- R9: A `fold_lvl` of 0 behaves as level 1, and a value above 16 behaves as level 16.
- R10: A write (`cfg_we` high at an edge) stores the truth table, output-select and feedback bits into context `cfg_idx`. A write to the active context changes `lut_out` from the next cycle on, not in the write cycle.
- R11: At level 1, three contexts compute i = a·b·c', then l = (i'+e'+f')·h' with i fed back, then OUT = d'·g' + l with l fed back. `lut_out` shows OUT in the third cycle after reset, and `reg_out` holds it in the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also samples the folding level |
| din | input | 4 | LUT data inputs |
| fold_lvl | input | 5 | Folding level p, 1 to 16 |
| cfg_we | input | 1 | Context write enable |
| cfg_idx | input | 4 | Context index to write |
| cfg_tt | input | 16 | Truth table; bit A is the output for address A |
| cfg_reg | input | 1 | Output-select bit: 1 selects the registered output on `sel_out` |
| cfg_fb | input | 1 | Feedback bit: 1 replaces address bit 3 with `reg_out` |
| active_ctx | output | 4 | Index of the context now in use |
| lut_out | output | 1 | Combinational LUT result |
| reg_out | output | 1 | Registered LUT result |
| sel_out | output | 1 | Output chosen by the output-select bit |

## Verification
The assertions check on every cycle that the following hold:
- the evaluation count stays below the latched level;
- the pointer only steps by one, and wraps, after a full count;
- the latched level stays in range and does not move outside reset;
- the register captures the previous LUT result;
- a write to the active context is visible one cycle later.

Only the bench scenarios can show that the right truth-table bit is selected for every input pattern, and that feedback and output selection follow each context's bits. The same holds for the exact dwell of p cycles per context at several levels, including the clamped levels. The folded three-stage function is checked over all 256 input combinations.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
    localparam int LUT_IN = 4;
    localparam int TT_W   = 1 << LUT_IN;

    typedef struct packed {
        logic            fb_sel;
        logic            reg_sel;
        logic [TT_W-1:0] tt;
    } ctx_cfg_t;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_EVAL = 2'd1,
        ST_LAST = 2'd2
    } seq_state_t;
endpackage

// File: rtl/mcf_ctx_store.sv
module mcf_ctx_store
    import mcf_pkg::*;
#(
    parameter int NUM_CTX = 16,
    localparam int CTX_W = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_idx,
    input  ctx_cfg_t         wr_cfg,
    input  logic [CTX_W-1:0] rd_idx,
    output ctx_cfg_t         rd_cfg
);
    ctx_cfg_t mem [NUM_CTX];

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_idx) < NUM_CTX)) begin
            mem[wr_idx] <= wr_cfg;
        end
    end

    assign rd_cfg = mem[rd_idx];
endmodule

// File: rtl/mcf_lut.sv
module mcf_lut
    import mcf_pkg::*;
(
    input  ctx_cfg_t          cfg,
    input  logic [LUT_IN-1:0] din,
    input  logic              fb_bit,
    output logic              lut_out
);
    logic [LUT_IN-1:0] addr;

    always_comb begin
        addr = din;
        if (cfg.fb_sel) begin
            addr[LUT_IN-1] = fb_bit;
        end
        lut_out = cfg.tt[addr];
    end
endmodule

// File: rtl/mcf_sequencer.sv
module mcf_sequencer
    import mcf_pkg::*;
#(
    parameter int NUM_CTX  = 16,
    parameter int MAX_FOLD = 16,
    localparam int CTX_W = $clog2(NUM_CTX),
    localparam int LVL_W = $clog2(MAX_FOLD + 1),
    localparam int CNT_W = (MAX_FOLD > 1) ? $clog2(MAX_FOLD) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] fold_lvl,
    output logic [CTX_W-1:0] ctx_ptr
);
    seq_state_t       state, state_nxt;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] last_idx;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [CTX_W-1:0] ptr_nxt;
    logic             adv;

    function automatic logic [LVL_W-1:0] clamp_lvl(input logic [LVL_W-1:0] v);
        if (v == '0) return LVL_W'(1);
        if (32'(v) > MAX_FOLD) return LVL_W'(MAX_FOLD);
        return v;
    endfunction

    assign last_idx = lvl_q - LVL_W'(1);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HOLD;
            lvl_q   <= clamp_lvl(fold_lvl);
            cnt     <= '0;
            ctx_ptr <= '0;
        end else begin
            state   <= state_nxt;
            cnt     <= cnt_nxt;
            ctx_ptr <= ptr_nxt;
        end
    end

    // next-state and sequencing outputs
    always_comb begin
        adv = 1'b0;
        unique case (state)
            ST_HOLD, ST_EVAL: adv = (LVL_W'(cnt) == last_idx);
            ST_LAST:          adv = 1'b1;
            default:          adv = 1'b0;
        endcase
        cnt_nxt = adv ? '0 : cnt + CNT_W'(1);
        if (adv) begin
            ptr_nxt = (ctx_ptr == CTX_W'(NUM_CTX - 1)) ? '0 : ctx_ptr + CTX_W'(1);
        end else begin
            ptr_nxt = ctx_ptr;
        end
        state_nxt = (LVL_W'(cnt_nxt) == last_idx) ? ST_LAST : ST_EVAL;
    end

    // R1: pointer and count cleared after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctx_ptr == '0 && cnt == '0));

    // R6: evaluation count never reaches the level
    a_r6_cnt_below_level: assert property (@(posedge clk) disable iff (rst)
        LVL_W'(cnt) < lvl_q);

    // R6: pointer moves only after a full count
    a_r6_step_after_full: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ctx_ptr != $past(ctx_ptr)) |-> (LVL_W'($past(cnt)) == $past(last_idx)));

    // R7: pointer steps by one and wraps
    a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ctx_ptr != $past(ctx_ptr)) |->
        (ctx_ptr == (($past(ctx_ptr) == CTX_W'(NUM_CTX - 1)) ? '0 : $past(ctx_ptr) + CTX_W'(1))));

    // R9: latched level within 1..MAX_FOLD
    a_r9_level_range: assert property (@(posedge clk) disable iff (rst)
        (lvl_q >= LVL_W'(1) && 32'(lvl_q) <= MAX_FOLD));

    // R8: level does not move outside reset
    a_r8_level_stable: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $stable(lvl_q));
endmodule

// File: rtl/mctx_fold_cell.sv
module mctx_fold_cell
    import mcf_pkg::*;
#(
    parameter int NUM_CTX  = 16,
    parameter int MAX_FOLD = 16,
    localparam int CTX_W = $clog2(NUM_CTX),
    localparam int LVL_W = $clog2(MAX_FOLD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LUT_IN-1:0] din,
    input  logic [LVL_W-1:0]  fold_lvl,
    input  logic              cfg_we,
    input  logic [CTX_W-1:0]  cfg_idx,
    input  logic [TT_W-1:0]   cfg_tt,
    input  logic              cfg_reg,
    input  logic              cfg_fb,
    output logic [CTX_W-1:0]  active_ctx,
    output logic              lut_out,
    output logic              reg_out,
    output logic              sel_out
);
    ctx_cfg_t wr_cfg;
    ctx_cfg_t cur_cfg;

    assign wr_cfg = '{fb_sel: cfg_fb, reg_sel: cfg_reg, tt: cfg_tt};

    mcf_sequencer #(.NUM_CTX(NUM_CTX), .MAX_FOLD(MAX_FOLD)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .fold_lvl(fold_lvl),
        .ctx_ptr (active_ctx)
    );

    mcf_ctx_store #(.NUM_CTX(NUM_CTX)) store_i (
        .clk   (clk),
        .wr_en (cfg_we),
        .wr_idx(cfg_idx),
        .wr_cfg(wr_cfg),
        .rd_idx(active_ctx),
        .rd_cfg(cur_cfg)
    );

    mcf_lut lut_i (
        .cfg    (cur_cfg),
        .din    (din),
        .fb_bit (reg_out),
        .lut_out(lut_out)
    );

    always_ff @(posedge clk) begin
        if (rst) reg_out <= 1'b0;
        else     reg_out <= lut_out;
    end

    assign sel_out = cur_cfg.reg_sel ? reg_out : lut_out;

    // R3: register holds the previous LUT result
    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (reg_out == $past(lut_out)));

    // R10: write to the active context visible next cycle
    a_r10_write_visible: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(cfg_we) && $past(cfg_idx) == $past(active_ctx) && $stable(active_ctx))
        |-> (cur_cfg.tt == $past(cfg_tt)));
endmodule

// File: tb/mctx_fold_cell_tb_top.sv
module mctx_fold_cell_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  din = '0;
    logic [4:0]  fold_lvl = 5'd1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [15:0] cfg_tt = '0;
    logic        cfg_reg = 1'b0;
    logic        cfg_fb = 1'b0;
    logic [3:0]  active_ctx;
    logic        lut_out, reg_out, sel_out;

    int errors = 0;
    int checks = 0;

    logic [15:0] tt_m [16];
    logic        rs_m [16];
    logic        fb_m [16];
    int          m_ctx, m_cnt, m_lvl;
    logic        m_reg;

    always #2 clk = ~clk;

    mctx_fold_cell dut_i (
        .clk(clk), .rst(rst), .din(din), .fold_lvl(fold_lvl),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_tt(cfg_tt),
        .cfg_reg(cfg_reg), .cfg_fb(cfg_fb),
        .active_ctx(active_ctx), .lut_out(lut_out),
        .reg_out(reg_out), .sel_out(sel_out)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
        end
    endtask

    function automatic logic exp_lut(input int c, input logic [3:0] d, input logic r);
        logic [3:0] a;
        a = d;
        if (fb_m[c]) a[3] = r;
        return tt_m[c][a];
    endfunction

    task automatic put_ctx(input int idx, input logic [15:0] tt, input logic rs, input logic fb);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_tt = tt; cfg_reg = rs; cfg_fb = fb;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        tt_m[idx] = tt; rs_m[idx] = rs; fb_m[idx] = fb;
    endtask

    task automatic do_reset(input int lvl);
        rst = 1'b1;
        fold_lvl = 5'(lvl);
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        m_ctx = 0; m_cnt = 0; m_reg = 1'b0;
        m_lvl = (lvl == 0) ? 1 : ((lvl > 16) ? 16 : lvl);
        chk("R1", "active_ctx", int'(active_ctx), 0);
        chk("R1", "reg_out", int'(reg_out), 0);
    endtask

    // runs ncyc evaluation cycles against the bench model
    task automatic run(input int ncyc, input string ctag, input int seed,
                       input int wr_cyc, input logic [15:0] wr_tt, input int new_lvl);
        bit wrapped = 0;
        if (new_lvl >= 0) fold_lvl = 5'(new_lvl);
        for (int i = 0; i < ncyc; i++) begin
            logic e_lut, e_sel;
            string ltag;
            int wr_ctx;
            din = 4'((i * 5 + seed) ^ (i >> 4));
            wr_ctx = m_ctx;
            if (i == wr_cyc) begin
                cfg_we = 1'b1; cfg_idx = 4'(m_ctx); cfg_tt = wr_tt;
                cfg_reg = rs_m[m_ctx]; cfg_fb = fb_m[m_ctx];
            end
            #1;
            e_lut = exp_lut(m_ctx, din, m_reg);
            e_sel = rs_m[m_ctx] ? m_reg : e_lut;
            ltag = (i == wr_cyc || i == wr_cyc + 1) ? "R10" : (fb_m[m_ctx] ? "R5" : "R2");
            chk((wrapped && m_ctx == 0) ? "R7" : ctag, "active_ctx", int'(active_ctx), m_ctx);
            chk(ltag, "lut_out", int'(lut_out), int'(e_lut));
            chk("R3", "reg_out", int'(reg_out), int'(m_reg));
            chk("R4", "sel_out", int'(sel_out), int'(e_sel));
            @(posedge clk); #1;
            cfg_we = 1'b0;
            if (i == wr_cyc) tt_m[wr_ctx] = wr_tt;
            m_reg = e_lut;
            if (m_cnt == m_lvl - 1) begin
                m_cnt = 0;
                if (m_ctx == 15) wrapped = 1;
                m_ctx = (m_ctx + 1) % 16;
            end else begin
                m_cnt++;
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 16; c++) begin
            put_ctx(c, 16'(32'hA5C3 * (c + 1)) ^ 16'(c << 8), c[1], c[0]);
        end
        do_reset(1);
        run(40, "R6", 3, -1, 16'h0, -1);
        do_reset(2);
        run(70, "R6", 1, -1, 16'h0, -1);
        do_reset(3);
        run(60, "R8", 7, -1, 16'h0, 1);
        do_reset(0);
        run(36, "R9", 2, -1, 16'h0, -1);
        do_reset(20);
        run(40, "R9", 5, 5, 16'h5AA5, -1);
        do_reset(16);
        run(270, "R6", 9, 20, 16'h3C0F, -1);

        // R11: three-stage folded function at level 1
        begin
            logic [15:0] t0, t1, t2;
            for (int x = 0; x < 16; x++) begin
                t0[x] = x[0] & x[1] & ~x[2];
                t1[x] = (~x[3] | ~x[0] | ~x[1]) & ~x[2];
                t2[x] = (~x[0] & ~x[1]) | x[3];
            end
            put_ctx(0, t0, 1'b0, 1'b0);
            put_ctx(1, t1, 1'b0, 1'b1);
            put_ctx(2, t2, 1'b0, 1'b1);
        end
        for (int v = 0; v < 256; v++) begin
            logic a, b, c, e, f, h, d, g, iv, lv, ov;
            {g, d, h, f, e, c, b, a} = 8'(v);
            iv = a & b & ~c;
            lv = (~iv | ~e | ~f) & ~h;
            ov = (~d & ~g) | lv;
            do_reset(1);
            din = {1'b0, c, b, a};
            @(posedge clk); #1;
            din = {1'b0, h, f, e};
            @(posedge clk); #1;
            din = {1'b0, 1'b0, g, d};
            #1;
            chk("R11", "lut_out stage3", int'(lut_out), int'(ov));
            @(posedge clk); #1;
            chk("R11", "reg_out stage3", int'(reg_out), int'(ov));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule